// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a 32-bit processor core, along with the current and saved status words. Some registers have private copies for each privileged mode. The active copy is chosen by the 5-bit mode field in the low bits of the current status word. The fast-interrupt mode has its own R8 through R14. The interrupt, supervisor, abort and undefined modes each have their own R13 and R14 and share every other register with user mode.

The core reads two registers per cycle through combinational ports and writes one register per clock edge. A move-to-status operation updates either the current or the saved status word, one byte field at a time, under a 4-bit field mask. All storage sits in a single 31-entry physical array, so a mode switch costs no cycles. A combinational map turns (mode, register number) into a physical slot. Every port completes in one cycle and can never stall, so no valid/ready handshake is present. Nothing in the block can apply back-pressure.

Top module: `banked_regfile`

## Requirements
- R1: After reset the current status word reads 0x00000013 (supervisor), the saved status word reads 0, and every register reads 0 in every mode.
- R2: Both read ports are combinational and independent. Each returns the value of the named register in the bank selected by the current mode.
- R3: When `wr_en` is high, `wr_data` is stored at the clock edge into the named register of the current mode's bank. A read of that register in the same cycle still returns the old value.
- R4: In mode 0x11 (fast interrupt), R8 to R14 are private copies, distinct from the user registers and from every other mode.
- R5: In modes 0x12 (interrupt), 0x13 (supervisor), 0x17 (abort) and 0x1B (undefined), only R13 and R14 are private. R0 to R12 and R15 are shared with user mode.
- R6: Any other mode value (for example 0x10, 0x1F, 0x00) uses the unbanked user set.
- R7: A value written to a banked register reappears when the core leaves that mode and later returns to it. Writes made in other modes do not disturb it.
- R8: A status write computes new = (old AND NOT m) OR (data AND m). The mask m is built from `psr_fld`: bit 0 gives 0x000000DF, bit 1 gives 0x0000FF00, bit 2 gives 0x00FF0000 and bit 3 gives 0xFF000000. Status bit 5 is therefore never written.
- R9: When `psr_sel_saved` is high, the write goes only to the saved status word. The current status word and the register mapping stay unchanged.
- R10: A mode change written at edge N steers reads and writes from the following cycle onward. A register write issued in the same cycle as the status write lands in the old mode's bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | 32 | Register write data |
| psr_wr_en | input | 1 | Status write enable |
| psr_sel_saved | input | 1 | 1 = target the saved status word, 0 = the current one |
| psr_fld | input | 4 | Byte-field enables, bit k covers status byte k |
| psr_wr_data | input | 32 | Status write data |
| cpsr_out | output | 32 | Current status word |
| spsr_out | output | 32 | Saved status word |

## Verification
The hardest case to reach is a register write that coincides with a mode change. The value must land in the old bank and then show up only after the core returns to that mode. Getting there needs a chain of status writes through several modes with banked writes scattered among them. The stimulus runs directed round trips through every privileged mode first. It then issues random writes, reads and field-masked status writes that pick mode values from the banked set and from unbanked codes, so same-cycle collisions happen often. A behavioural model that swaps banks in and out on each mode change is compared against both read ports and both status words every cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int LOG_REGS  = 16;
  localparam int LIDX_W    = $clog2(LOG_REGS);
  localparam int FIQ_FIRST = 8;
  localparam int FIQ_CNT   = 7;
  localparam int PAIR_CNT  = 2;
  localparam int PAIR_MODES = 4;
  localparam int PHYS_REGS = LOG_REGS + FIQ_CNT + PAIR_MODES * PAIR_CNT;
  localparam int PIDX_W    = $clog2(PHYS_REGS);

  typedef enum logic [4:0] {
    M_FIQ = 5'h11,
    M_IRQ = 5'h12,
    M_SVC = 5'h13,
    M_ABT = 5'h17,
    M_UND = 5'h1B
  } bank_mode_e;

  function automatic logic [PIDX_W-1:0] phys_slot(input logic [4:0] mode,
                                                  input logic [LIDX_W-1:0] lidx);
    logic [PIDX_W-1:0] slot;
    int pair_base;
    slot = PIDX_W'(lidx);
    pair_base = -1;
    case (mode)
      M_FIQ: begin
        if (int'(lidx) >= FIQ_FIRST && int'(lidx) < FIQ_FIRST + FIQ_CNT)
          slot = PIDX_W'(LOG_REGS + int'(lidx) - FIQ_FIRST);
      end
      M_IRQ: pair_base = LOG_REGS + FIQ_CNT;
      M_SVC: pair_base = LOG_REGS + FIQ_CNT + PAIR_CNT;
      M_ABT: pair_base = LOG_REGS + FIQ_CNT + 2 * PAIR_CNT;
      M_UND: pair_base = LOG_REGS + FIQ_CNT + 3 * PAIR_CNT;
      default: ;
    endcase
    if (pair_base >= 0 && int'(lidx) >= 13 && int'(lidx) < 13 + PAIR_CNT)
      slot = PIDX_W'(pair_base + int'(lidx) - 13);
    return slot;
  endfunction
endpackage

// File: rtl/bank_map.sv
module bank_map
  import regbank_pkg::*;
(
  input  logic [4:0]        mode,
  input  logic [LIDX_W-1:0] lidx,
  output logic [PIDX_W-1:0] pidx
);
  always_comb pidx = phys_slot(mode, lidx);
endmodule

// File: rtl/reg_array.sv
module reg_array #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 31,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cells[i] <= '0;
      else if (we && waddr == AW'(i))
        cells[i] <= wdata;
    end
  end

  always_comb begin
    rdata_a = (int'(raddr_a) < DEPTH) ? cells[raddr_a] : '0;
    rdata_b = (int'(raddr_b) < DEPTH) ? cells[raddr_b] : '0;
  end
endmodule

// File: rtl/psr_unit.sv
module psr_unit #(
  parameter int DATA_W = 32,
  parameter logic [7:0] CTRL_MASK = 8'hDF,
  parameter logic [4:0] RESET_MODE = 5'h13,
  localparam int NFLD = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel_saved,
  input  logic [NFLD-1:0]   fld,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cpsr,
  output logic [DATA_W-1:0] spsr
);
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] target;

  for (genvar k = 0; k < NFLD; k++) begin : g_lane
    if (k == 0) begin : g_ctrl
      assign mask[7:0] = fld[0] ? CTRL_MASK : 8'h00;
    end else begin : g_plain
      assign mask[8*k +: 8] = fld[k] ? 8'hFF : 8'h00;
    end
  end

  always_comb begin
    target = sel_saved ? spsr : cpsr;
    target = (target & ~mask) | (wdata & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpsr <= DATA_W'(RESET_MODE);
      spsr <= '0;
    end else if (wr_en) begin
      if (sel_saved) spsr <= target;
      else           cpsr <= target;
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              psr_wr_en,
  input  logic              psr_sel_saved,
  input  logic [3:0]        psr_fld,
  input  logic [DATA_W-1:0] psr_wr_data,
  output logic [DATA_W-1:0] cpsr_out,
  output logic [DATA_W-1:0] spsr_out
);
  logic [4:0]        cur_mode;
  logic [PIDX_W-1:0] pa, pb, pw;

  assign cur_mode = cpsr_out[4:0];

  bank_map u_map_a (.mode(cur_mode), .lidx(rd_a_idx), .pidx(pa));
  bank_map u_map_b (.mode(cur_mode), .lidx(rd_b_idx), .pidx(pb));
  bank_map u_map_w (.mode(cur_mode), .lidx(wr_idx),   .pidx(pw));

  reg_array #(.DATA_W(DATA_W), .DEPTH(PHYS_REGS)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en), .waddr(pw), .wdata(wr_data),
    .raddr_a(pa), .raddr_b(pb),
    .rdata_a(rd_a_data), .rdata_b(rd_b_data)
  );

  psr_unit #(.DATA_W(DATA_W), .RESET_MODE(5'h13)) u_psr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(psr_wr_en), .sel_saved(psr_sel_saved),
    .fld(psr_fld), .wdata(psr_wr_data),
    .cpsr(cpsr_out), .spsr(spsr_out)
  );
endmodule

// File: rtl/regbank_checker.sv
module regbank_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        psr_wr_en,
  input logic        psr_sel_saved,
  input logic [3:0]  psr_fld,
  input logic [3:0]  rd_a_idx,
  input logic [31:0] rd_a_data,
  input logic [31:0] cpsr_out
);
  // R2: with no write of any kind, an unchanged read index returns an unchanged value
  a_r2_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !psr_wr_en) |=> ($stable(rd_a_idx) -> $stable(rd_a_data)));

  // R8: status bit 5 is outside every field mask
  a_r8_bit5_locked: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(cpsr_out[5]));

  // R8: a disabled top field keeps its byte
  a_r8_top_field_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_wr_en && !psr_fld[3]) |=> $stable(cpsr_out[31:24]));

  // R8: without a status write the current status word holds
  a_r8_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !psr_wr_en |=> $stable(cpsr_out));

  // R9: a saved-status write leaves the current word and its mode alone
  a_r9_saved_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_wr_en && psr_sel_saved) |=> $stable(cpsr_out));
endmodule

bind banked_regfile regbank_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .psr_wr_en(psr_wr_en),
  .psr_sel_saved(psr_sel_saved), .psr_fld(psr_fld),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .cpsr_out(cpsr_out)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, psr_fld = '0;
  logic [31:0] rd_a_data, rd_b_data, cpsr_out, spsr_out;
  logic        wr_en = 1'b0, psr_wr_en = 1'b0, psr_sel_saved = 1'b0;
  logic [31:0] wr_data = '0, psr_wr_data = '0;

  always #2.5 clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .psr_wr_en(psr_wr_en), .psr_sel_saved(psr_sel_saved),
    .psr_fld(psr_fld), .psr_wr_data(psr_wr_data),
    .cpsr_out(cpsr_out), .spsr_out(spsr_out)
  );

  // Reference: visible registers plus an off-screen store per banked mode, swapped on mode change
  logic [31:0] vis [16];
  logic [31:0] store [5][7];
  logic [31:0] m_cpsr, m_spsr;
  int nvec = 0, nbad = 0;
  bit done = 0;

  function automatic int slot_of(input logic [4:0] m);
    case (m)
      5'h11: return 0;
      5'h12: return 1;
      5'h13: return 2;
      5'h17: return 3;
      5'h1B: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic swap_bank(input logic [4:0] m);
    int s, base, cnt;
    logic [31:0] t;
    s = slot_of(m);
    if (s < 0) return;
    base = (s == 0) ? 8 : 13;
    cnt  = (s == 0) ? 7 : 2;
    for (int j = 0; j < cnt; j++) begin
      t = vis[base + j];
      vis[base + j] = store[s][j];
      store[s][j] = t;
    end
  endtask

  function automatic logic [31:0] fld_mask(input logic [3:0] f);
    logic [31:0] m;
    m = 0;
    if (f[0]) m |= 32'h0000_00DF;
    if (f[1]) m |= 32'h0000_FF00;
    if (f[2]) m |= 32'h00FF_0000;
    if (f[3]) m |= 32'hFF00_0000;
    return m;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) vis[i] = '0;
    for (int s = 0; s < 5; s++) for (int j = 0; j < 7; j++) store[s][j] = '0;
    m_cpsr = 32'h13;
    m_spsr = '0;
  endtask

  task automatic cmp(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s %s got %08h expected %08h", tag, what, got, exp);
    end
  endtask

  task automatic step(input string tag, input bit we, input logic [3:0] wi, input logic [31:0] wd,
                      input bit pe, input bit ps, input logic [3:0] pf, input logic [31:0] pd,
                      input logic [3:0] ra, input logic [3:0] rb);
    logic [4:0] oldm, newm;
    logic [31:0] mk;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd;
    psr_wr_en = pe; psr_sel_saved = ps; psr_fld = pf; psr_wr_data = pd;
    rd_a_idx = ra; rd_b_idx = rb;
    #1;
    nvec++;
    cmp(tag, $sformatf("rd_a R%0d", ra), rd_a_data, vis[ra]);
    cmp(tag, $sformatf("rd_b R%0d", rb), rd_b_data, vis[rb]);
    cmp(tag, "cpsr", cpsr_out, m_cpsr);
    cmp(tag, "spsr", spsr_out, m_spsr);
    @(posedge clk);
    oldm = m_cpsr[4:0];
    if (we) vis[wi] = wd;
    if (pe) begin
      mk = fld_mask(pf);
      if (ps) m_spsr = (m_spsr & ~mk) | (pd & mk);
      else    m_cpsr = (m_cpsr & ~mk) | (pd & mk);
    end
    newm = m_cpsr[4:0];
    if (oldm != newm) begin
      swap_bank(oldm);
      swap_bank(newm);
    end
  endtask

  task automatic wreg(input string tag, input logic [3:0] i, input logic [31:0] d);
    step(tag, 1, i, d, 0, 0, 4'h0, 0, i, 4'(i + 1));
  endtask

  task automatic setmode(input string tag, input logic [4:0] m);
    step(tag, 0, 0, 0, 1, 0, 4'b0001, {27'h0, m}, 4'd13, 4'd14);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 16; i += 2) step(tag, 0, 0, 0, 0, 0, 0, 0, 4'(i), 4'(i + 1));
  endtask

  task automatic fill(input string tag, input logic [7:0] tagbyte);
    for (int i = 0; i < 16; i++) wreg(tag, 4'(i), {tagbyte, 20'h0, 4'(i)});
  endtask

  localparam logic [4:0] MODES [8] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h00};

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    read_all("R1");                      // R1: reset state
    fill("R3", 8'hA3);                   // R3: writes in supervisor
    read_all("R2");                      // R2: two read ports
    step("R3", 1, 4'd5, 32'h5555_0000, 0, 0, 0, 0, 4'd5, 4'd5); // R3: same-cycle read sees old value
    read_all("R3");
    setmode("R6", 5'h10);                // R6: user set
    read_all("R6");
    fill("R6", 8'hB6);
    setmode("R4", 5'h11);                // R4: fast interrupt privates
    read_all("R4");
    fill("R4", 8'hC4);
    foreach (MODES[k]) begin
      setmode("R5", MODES[k]);           // R5: pair-banked modes share R0-R12
      read_all("R5");
      wreg("R5", 4'd13, {8'hD5, 19'h0, MODES[k]});
      wreg("R5", 4'd14, {8'hE5, 19'h0, MODES[k]});
    end
    foreach (MODES[k]) begin
      setmode("R7", MODES[k]);           // R7: banked values survive round trips
      read_all("R7");
    end
    // R10: register write together with a mode change lands in the old bank
    step("R10", 1, 4'd13, 32'h1010_1010, 1, 0, 4'b0001, 32'h12, 4'd13, 4'd14);
    step("R10", 1, 4'd13, 32'h2020_2020, 0, 0, 0, 0, 4'd13, 4'd14);
    setmode("R10", 5'h13);
    read_all("R10");
    setmode("R10", 5'h1F);
    read_all("R10");
    // R9: saved-status writes leave the mapping alone
    step("R9", 0, 0, 0, 1, 1, 4'b1111, 32'hFFFF_FF11, 4'd8, 4'd13);
    read_all("R9");
    // R8: each field alone and bit 5 locked
    for (int f = 0; f < 16; f++)
      step("R8", 0, 0, 0, 1, 0, 4'(f), 32'hA5C3_96F0 ^ (32'h0101_0101 * f) | 32'h20, 4'd0, 4'd15);
    setmode("R8", 5'h13);
    read_all("R8");
    // mixed random traffic
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step("R7", r[0], 4'($urandom), $urandom, (r[3:1] == 0), r[4], 4'($urandom),
           {$urandom_range(0, 32'h7FF_FFFF), MODES[r[7:5]]}, 4'($urandom), 4'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired after %0d vectors, expected completion", nvec);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule